// File: doc/BRIEF.md
# Looping Sample Address Engine

This block tracks the playback position of a single channel in a sampled-audio voice. The position is a fixed-point value: a 16-bit whole-sample offset with a 12-bit fraction below it. The offset is counted from the start of a loop. On every output-rate tick (48 kHz in the target system), the position moves forward by a rate-ratio step in 4.12 format, which is the source rate divided by the output rate. When the offset reaches the loop end offset, the loop length is subtracted from it. The fraction carries through the wrap unchanged, so playback stays inside the loop with no timing slip.

Each cycle the block presents four results. The first is the current offset. The second is the fraction, which a downstream interpolator uses to weight this sample against the next one. The third is the byte address of the current sample frame, formed from an aligned loop start address and a scale that depends on the sample format. The fourth is a pair of loop flags: a one-cycle pulse when a wrap happens, and a level that shows the position is in the second half of the loop. A single load strobe sets the whole channel state at once.

Top module: `sae_loop_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the offset, fraction and address go to zero and both loop flags go low.
- R2: A clock edge with `load_i` high captures the offset, step, loop end, start address and format. It also captures the fraction when `load_frac_vld_i` is high and sets the fraction to zero when it is low. A load takes priority over a tick in the same cycle, and the wrap pulse is low after a load.
- R3: A clock edge with `tick_i` high and `load_i` low adds the 16-bit step (4 integer bits, 12 fraction bits) to the 16.12 position. Fraction overflow carries into the offset.
- R4: A clock edge with both `tick_i` and `load_i` low leaves the offset and fraction unchanged, and the wrap pulse is low after it.
- R5: When the loop end is nonzero and the offset after a tick is greater than or equal to the loop end, the loop end is subtracted once and the fraction is kept. `loop_wrap_o` is high for exactly the cycle after that tick. A loop end of at least 16 is assumed, so that one subtraction brings the offset back inside the loop.
- R6: A loop end of zero disables looping. The offset then runs freely modulo 65536, `loop_wrap_o` stays low and `loop_mid_o` stays low.
- R7: With a nonzero loop end, `loop_mid_o` is high exactly when the current offset is greater than or equal to the loop end shifted right by one.
- R8: `addr_o` equals the aligned start address plus the offset times the frame size, modulo 2^31. Format code 0 is 8-bit mono (1 byte), code 1 is 16-bit mono (2 bytes), code 2 is 8-bit stereo (2 bytes) and code 3 is 16-bit stereo (4 bytes).
- R9: For address generation, the start address has bit 0 cleared in the 2-byte formats and bits 1:0 cleared in the 4-byte format. It is used unchanged in the 1-byte format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load the full channel state |
| load_frac_vld_i | input | 1 | Take `load_frac_i` on load; otherwise load a zero fraction |
| load_ofs_i | input | 16 | Offset to load |
| load_frac_i | input | 12 | Fraction to load |
| load_step_i | input | 16 | Rate-ratio step, 4.12 |
| load_end_i | input | 16 | Loop end offset (0 disables looping) |
| load_base_i | input | 31 | Loop start byte address |
| load_fmt_i | input | 2 | Sample format code |
| tick_i | input | 1 | Output-rate advance strobe |
| ofs_o | output | 16 | Current sample offset |
| frac_o | output | 12 | Interpolation fraction |
| addr_o | output | 31 | Byte address of the current sample frame |
| loop_wrap_o | output | 1 | Wrap pulse, one cycle |
| loop_mid_o | output | 1 | Offset in the second half of the loop |

## Verification
Offset, fraction and the wrap pulse are all registered at the edge that takes a load or a tick, so each is due one edge after the strobe. Address and mid flag are combinational from that state and share the same single-edge latency. The bench drives every strobe on a falling edge, releases it on the next falling edge, and compares every output against its arithmetic model there, half a period after the edge that acted. A sweep over all four formats, several steps, loop lengths and fractional start points runs many wraps, and separate sequences cover idle cycles, a load that collides with a tick, the free-running 16-bit wrap and address alignment.

// File: rtl/sae_pkg.sv
// Shared types for the looping sample address engine.
// Assumes two format bits; frame size is a power of two up to 4 bytes.
package sae_pkg;

    typedef enum logic [1:0] {
        FMT_M8  = 2'd0,   // 8-bit mono, 1 byte per frame
        FMT_M16 = 2'd1,   // 16-bit mono, 2 bytes per frame
        FMT_S8  = 2'd2,   // 8-bit stereo, 2 bytes per frame
        FMT_S16 = 2'd3    // 16-bit stereo, 4 bytes per frame
    } smp_fmt_e;

    // log2 of the bytes per frame for a format
    function automatic logic [1:0] fmt_shift(smp_fmt_e f);
        case (f)
            FMT_M8:  return 2'd0;
            FMT_S16: return 2'd2;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/sae_phase_acc.sv
// Fixed-point position accumulator with single-subtraction loop wrap.
// Holds an OFS_W.FRAC_W position, adds the step on each tick, and
// subtracts the loop end once when the advanced offset reaches it.
// Assumes a nonzero loop end is large enough (>= 16 for a 4.12 step)
// that one subtraction lands inside the loop. Loop end zero = free run.
module sae_phase_acc #(
    parameter int OFS_W  = 16,
    parameter int FRAC_W = 12,
    parameter int STEP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [OFS_W-1:0]  ld_ofs_i,
    input  logic [FRAC_W-1:0] ld_frac_i,
    input  logic              tick_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [OFS_W-1:0]  end_i,
    output logic [OFS_W-1:0]  ofs_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              wrap_o
);
    localparam int POS_W = OFS_W + FRAC_W;
    localparam int SUM_W = POS_W + 1;
    localparam int SO_W  = OFS_W + 1;

    logic [OFS_W-1:0]  ofs_q;
    logic [FRAC_W-1:0] frac_q;
    logic              wrap_q;
    logic [SUM_W-1:0]  sum;
    logic [SO_W-1:0]   sum_ofs;
    logic              hit;
    logic [OFS_W-1:0]  nxt_ofs;

    // Advanced position and the wrap decision for the next tick
    always_comb begin
        sum     = {1'b0, ofs_q, frac_q} + SUM_W'(step_i);
        sum_ofs = sum[SUM_W-1:FRAC_W];
        hit     = (end_i != '0) && (sum_ofs >= {1'b0, end_i});
        nxt_ofs = hit ? OFS_W'(sum_ofs - {1'b0, end_i}) : sum_ofs[OFS_W-1:0];
    end

    // Position register: load beats tick, idle holds
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            frac_q <= '0;
            wrap_q <= 1'b0;
        end else if (load_i) begin
            ofs_q  <= ld_ofs_i;
            frac_q <= ld_frac_i;
            wrap_q <= 1'b0;
        end else if (tick_i) begin
            ofs_q  <= nxt_ofs;
            frac_q <= sum[FRAC_W-1:0];
            wrap_q <= hit;
        end else begin
            wrap_q <= 1'b0;
        end
    end

    assign ofs_o  = ofs_q;
    assign frac_o = frac_q;
    assign wrap_o = wrap_q;

    assert_load_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (ofs_q == $past(ld_ofs_i)) && (frac_q == $past(ld_frac_i)) && !wrap_q);

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(ofs_q) && $stable(frac_q) && !wrap_q);

    assert_wrap_inside_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_q && end_i >= OFS_W'(16)) |-> (ofs_q < end_i));

    assert_no_wrap_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i == '0) |=> !wrap_q);

endmodule

// File: rtl/sae_addr_gen.sv
// Byte address of the current frame: aligned start + offset * frame size.
// Drops the start address bits below the frame size. Result wraps
// modulo 2^ADDR_W. Purely combinational; clock is used by checks only.
module sae_addr_gen
    import sae_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int ADDR_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_i,
    input  smp_fmt_e          fmt_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [1:0]        sh;
    logic [ADDR_W-1:0] mask;

    // Align the start and add the scaled offset
    always_comb begin
        sh     = fmt_shift(fmt_i);
        mask   = (ADDR_W'(1) << sh) - ADDR_W'(1);
        addr_o = (base_i & ~mask) + (ADDR_W'(ofs_i) << sh);
    end

    assert_align_s16_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i == FMT_S16) |-> (addr_o[1:0] == 2'b00));

    assert_step_m8_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((fmt_i == FMT_M8) && $stable(fmt_i) && $stable(base_i)
         && (ofs_i == $past(ofs_i) + OFS_W'(1)))
        |-> (addr_o == $past(addr_o) + ADDR_W'(1)));

endmodule

// File: rtl/sae_loop_engine.sv
// Top of the looping sample address engine for one playback channel.
// Holds the channel configuration captured on load, drives the position
// accumulator and address generator, and derives the mid-loop level.
module sae_loop_engine
    import sae_pkg::*;
#(
    parameter int OFS_W  = 16,
    parameter int FRAC_W = 12,
    parameter int STEP_W = 16,
    parameter int ADDR_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              load_frac_vld_i,
    input  logic [OFS_W-1:0]  load_ofs_i,
    input  logic [FRAC_W-1:0] load_frac_i,
    input  logic [STEP_W-1:0] load_step_i,
    input  logic [OFS_W-1:0]  load_end_i,
    input  logic [ADDR_W-1:0] load_base_i,
    input  logic [1:0]        load_fmt_i,
    input  logic              tick_i,
    output logic [OFS_W-1:0]  ofs_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              loop_wrap_o,
    output logic              loop_mid_o
);
    logic [STEP_W-1:0] step_q;
    logic [OFS_W-1:0]  end_q;
    logic [ADDR_W-1:0] base_q;
    smp_fmt_e          fmt_q;
    logic [FRAC_W-1:0] ld_frac;
    logic [OFS_W-1:0]  ofs;

    // Channel configuration captured on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
            end_q  <= '0;
            base_q <= '0;
            fmt_q  <= FMT_M8;
        end else if (load_i) begin
            step_q <= load_step_i;
            end_q  <= load_end_i;
            base_q <= load_base_i;
            fmt_q  <= smp_fmt_e'(load_fmt_i);
        end
    end

    // Fraction defaults to zero when the loader supplies none
    always_comb ld_frac = load_frac_vld_i ? load_frac_i : '0;

    sae_phase_acc #(.OFS_W(OFS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .ld_ofs_i (load_ofs_i),
        .ld_frac_i(ld_frac),
        .tick_i   (tick_i),
        .step_i   (step_q),
        .end_i    (end_q),
        .ofs_o    (ofs),
        .frac_o   (frac_o),
        .wrap_o   (loop_wrap_o)
    );

    sae_addr_gen #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) agen_i (
        .clk   (clk),
        .rst_n (rst_n),
        .base_i(base_q),
        .fmt_i (fmt_q),
        .ofs_i (ofs),
        .addr_o(addr_o)
    );

    // Second-half-of-loop level; disabled when looping is off
    always_comb loop_mid_o = (end_q != '0) && (ofs >= (end_q >> 1));

    assign ofs_o = ofs;

    assert_mid_past_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((end_q != '0) && (ofs >= end_q)) |-> loop_mid_o);

    assert_mid_off_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_q == '0) |-> !loop_mid_o);

    assert_frac_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !load_frac_vld_i) |=> (frac_o == '0));

endmodule

// File: tb/sae_loop_engine_tb.sv
// Self-checking bench: sweeps formats, steps and loop lengths against an
// arithmetic model, plus idle, collision, free-run and alignment cases.
module sae_loop_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        fvld = 1'b0;
    logic [15:0] l_ofs = '0;
    logic [11:0] l_frac = '0;
    logic [15:0] l_step = '0;
    logic [15:0] l_end = '0;
    logic [30:0] l_base = '0;
    logic [1:0]  l_fmt = '0;
    logic        tick = 1'b0;
    logic [15:0] ofs_o;
    logic [11:0] frac_o;
    logic [30:0] addr_o;
    logic        wrap_o;
    logic        mid_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_ofs, m_frac, m_step, m_end, m_base, m_fmt, m_wrap;

    always #5 clk = ~clk;

    sae_loop_engine dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .load_frac_vld_i(fvld),
        .load_ofs_i(l_ofs), .load_frac_i(l_frac), .load_step_i(l_step),
        .load_end_i(l_end), .load_base_i(l_base), .load_fmt_i(l_fmt),
        .tick_i(tick), .ofs_o(ofs_o), .frac_o(frac_o), .addr_o(addr_o),
        .loop_wrap_o(wrap_o), .loop_mid_o(mid_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_addr();
        int sh = (m_fmt == 0) ? 0 : ((m_fmt == 3) ? 2 : 1);
        int al = m_base & ~((1 << sh) - 1);
        return (al + (m_ofs << sh)) & 32'h7FFF_FFFF;
    endfunction

    function automatic int exp_mid();
        return (m_end != 0 && m_ofs >= (m_end >> 1)) ? 1 : 0;
    endfunction

    task automatic check_all(input string req);
        chk(req, "ofs", int'(ofs_o), m_ofs);
        chk(req, "frac", int'(frac_o), m_frac);
        chk("R8", "addr", int'(addr_o), exp_addr());
        chk("R5", "wrap", int'(wrap_o), m_wrap);
        chk("R7", "mid", int'(mid_o), exp_mid());
    endtask

    task automatic do_load(input int o, input int f, input bit fv, input int st,
                           input int e, input int b, input int fm, input bit with_tick);
        @(negedge clk);
        l_ofs = 16'(o); l_frac = 12'(f); fvld = fv; l_step = 16'(st);
        l_end = 16'(e); l_base = 31'(b); l_fmt = 2'(fm);
        load = 1'b1; tick = with_tick;
        @(negedge clk);
        load = 1'b0; tick = 1'b0;
        m_ofs = o & 'hFFFF; m_frac = fv ? (f & 'hFFF) : 0; m_step = st & 'hFFFF;
        m_end = e & 'hFFFF; m_base = b & 32'h7FFF_FFFF; m_fmt = fm & 3; m_wrap = 0;
        check_all("R2");
    endtask

    task automatic do_tick();
        int pos, so;
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        pos = (m_ofs << 12) + m_frac + m_step;
        so = pos >> 12;
        m_frac = pos & 'hFFF;
        if (m_end != 0 && so >= m_end) begin
            so = so - m_end;
            m_wrap = 1;
        end else begin
            m_wrap = 0;
        end
        m_ofs = so & 'hFFFF;
        check_all("R3");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int steps [5] = '{'h1000, 'h0800, 'h1800, 'h0123, 'hFFFF};
        int ends  [3] = '{16, 40, 300};
        // R1: reset state
        l_load_dummy: begin end
        repeat (3) @(negedge clk);
        chk("R1", "ofs", int'(ofs_o), 0);
        chk("R1", "frac", int'(frac_o), 0);
        chk("R1", "addr", int'(addr_o), 0);
        chk("R1", "wrap", int'(wrap_o), 0);
        chk("R1", "mid", int'(mid_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: load without a fraction gives zero fraction
        do_load(5, 'hABC, 1'b0, 'h1000, 40, 'h100, 1, 1'b0);

        // Sweep formats, steps and loop lengths (R3, R5, R7, R8)
        for (int fm = 0; fm < 4; fm++)
            for (int si = 0; si < 5; si++)
                for (int ei = 0; ei < 3; ei++) begin
                    do_load(ei + si, 'h800 + si, 1'b1, steps[si], ends[ei],
                            'h4000_0000 + fm * 'h1000 + si, fm, 1'b0);
                    for (int k = 0; k < 40; k++) do_tick();
                end

        // R4: idle cycles hold position, wrap pulse drops
        do_load(14, 'hF00, 1'b1, 'h2000, 16, 'h20, 0, 1'b0);
        do_tick();
        repeat (3) @(negedge clk);
        chk("R4", "ofs idle", int'(ofs_o), m_ofs);
        chk("R4", "frac idle", int'(frac_o), m_frac);
        chk("R4", "wrap idle", int'(wrap_o), 0);
        m_wrap = 0;

        // R2: load collides with tick, load wins
        do_load(7, 'h123, 1'b1, 'h1000, 100, 'h50, 2, 1'b1);
        chk("R2", "collide ofs", int'(ofs_o), 7);

        // R6: loop end zero, free run across 16-bit boundary
        do_load('hFFFE, 0, 1'b1, 'h1800, 0, 'h10, 0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            do_tick();
            chk("R6", "wrap free", int'(wrap_o), 0);
            chk("R6", "mid free", int'(mid_o), 0);
        end
        chk("R6", "ofs rolled", int'(ofs_o), 4);

        // R5: exact hit keeps fraction
        do_load(15, 'h345, 1'b1, 'h1000, 16, 0, 0, 1'b0);
        do_tick();
        chk("R5", "exact wrap ofs", int'(ofs_o), 0);
        chk("R5", "frac kept", int'(frac_o), 'h345);
        chk("R5", "pulse", int'(wrap_o), 1);
        @(negedge clk);
        chk("R5", "pulse one cycle", int'(wrap_o), 0);
        m_wrap = 0;

        // R9: misaligned start address in each format
        do_load(5, 0, 1'b0, 'h1000, 100, 'h1237, 3, 1'b0);
        chk("R9", "s16 addr", int'(addr_o), 'h1234 + 20);
        do_load(5, 0, 1'b0, 'h1000, 100, 'h1237, 1, 1'b0);
        chk("R9", "m16 addr", int'(addr_o), 'h1236 + 10);
        do_load(5, 0, 1'b0, 'h1000, 100, 'h1237, 0, 1'b0);
        chk("R9", "m8 addr", int'(addr_o), 'h1237 + 5);

        // R8: address wraps modulo 2^31
        do_load(4, 0, 1'b0, 'h1000, 100, 'h7FFF_FFF8, 3, 1'b0);
        chk("R8", "addr wrap", int'(addr_o), 'h8);

        // R1: reset mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "ofs after reset", int'(ofs_o), 0);
        chk("R1", "addr after reset", int'(addr_o), 0);
        finish_run();
    end

endmodule